// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a frame received from a CAN or CAN FD bus should be kept. For each frame it receives a strobe with the 29-bit identifier field, a flag that says whether the identifier is extended, and a flag that says whether the frame is an FD frame. It holds three mask/value filters (A, B, C) and one range filter. Each filter has its own set of four frame-type enables. The frame is accepted when at least one present filter matches the identifier and allows the frame's type. A global filtering enable bypasses the whole bank, so that every frame is accepted.

Each filter can be removed at elaboration through a presence parameter. A removed filter keeps its register addresses, but those addresses read zero and ignore writes, and the filter never produces a hit. A read-only word reports which filters exist. Configuration uses a single-cycle register write port and a combinational read port. The decision comes out as a registered accept flag and a matching valid flag, one clock after the frame strobe.

Top module: `can_id_filter_bank`

## Requirements
- R1: After reset, accept_o and accept_vld_o are 0, the control word reads 0, the type-enable word reads 0x000F (filter A allows all four frame types, B, C and range allow none), and every filter threshold, mask and value word reads 0.
- R2: The identifier is a 29-bit field: the 11-bit base part sits in bits 28:18 and the 18-bit extension in bits 17:0. For a base-format frame (frm_ext_i=0), bits 17:0 are taken as zero before any comparison.
- R3: A mask/value filter matches when every identifier bit whose mask bit is 1 equals the same bit of the value word. Bits whose mask bit is 0 are not compared.
- R4: Frame type index t = {frm_fd_i, frm_ext_i}: 0 classic base, 1 classic extended, 2 FD base, 3 FD extended. Type-enable word bits [4f+3:4f] belong to filter f (0=A, 1=B, 2=C, 3=range), and bit 4f+t must be 1 for filter f to pass a frame of type t.
- R5: The range filter matches when low <= identifier <= high, both ends inclusive, using an unsigned comparison of 29-bit values.
- R6: With filtering enabled, a frame is accepted exactly when some present filter matches the identifier and has its enable bit set for the frame's type. Otherwise the frame is rejected.
- R7: With control bit 0 (filter enable) at 0, every frame is accepted whatever the filter settings.
- R8: A filter whose bit in PRESENT_MASK is 0 ignores writes to its words, reads zero from them and from its type-enable nibble, and never causes an acceptance.
- R9: The status word reads PRESENT_MASK in bits 3:0 (bit 0 A, bit 1 B, bit 2 C, bit 3 range) and zero above. Writes to it have no effect.
- R10: accept_vld_o is 1 exactly in the cycle after a cycle with frm_valid_i=1. accept_o then holds that frame's decision and keeps it until the next strobe.
- R11: Register word addresses: 0 control, 1 type enables, 2/3 A mask/value, 4/5 B mask/value, 6/7 C mask/value, 8/9 range low/high, 10 status. Writes take effect at the clock edge where reg_we_i=1, and reads return the stored value in the same cycle. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | ID_W | Write data |
| reg_rdata_o | output | ID_W | Read data for reg_addr_i |
| frm_valid_i | input | 1 | Frame identifier strobe |
| frm_id_i | input | ID_W | Frame identifier field |
| frm_ext_i | input | 1 | 1 when the identifier is extended |
| frm_fd_i | input | 1 | 1 when the frame is an FD frame |
| accept_o | output | 1 | Decision for the last strobed frame |
| accept_vld_o | output | 1 | Pulses one cycle after each strobe |

## Verification
The assertions assume that frm_valid_i, reg_we_i and reg_addr_i are never unknown after reset. They also assume that a frame strobe may coincide with a register write, in which case the decision uses the configuration from before that edge. The bench drives every input at the falling edge and never strobes a frame in a write cycle, so each expected decision depends only on completed writes. Random configurations use sparse masks, and identifiers are drawn near filter values and range ends, so that hits and misses both occur often. One instance has filters B and range removed, so the absent-filter behaviour is exercised under the same stimulus.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int unsigned N_FILT        = 4;
  localparam int unsigned N_MASK_FILT   = 3;
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_ENA      = 1;
  localparam int unsigned ADDR_CFG_BASE = 2;
  localparam int unsigned ADDR_STATUS   = 10;

  typedef enum logic [1:0] {
    FT_CLS_BASE = 2'd0,
    FT_CLS_EXT  = 2'd1,
    FT_FD_BASE  = 2'd2,
    FT_FD_EXT   = 2'd3
  } frame_type_e;

  // slot 0: mask / low threshold, slot 1: value / high threshold
  function automatic int unsigned cfg_addr(int unsigned filt, int unsigned slot);
    return ADDR_CFG_BASE + 2 * filt + slot;
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int unsigned ID_W         = 29,
  parameter int unsigned ADDR_W       = 4,
  parameter logic [3:0]  PRESENT_MASK = 4'hF
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [ID_W-1:0]                   wdata_i,
  output logic [ID_W-1:0]                   rdata_o,
  output logic                              filt_en_o,
  output logic [N_FILT-1:0][3:0]            type_ena_o,
  output logic [N_FILT-1:0][ID_W-1:0]       cfg0_o,
  output logic [N_FILT-1:0][ID_W-1:0]       cfg1_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (we_i && addr_i == ADDR_W'(ADDR_CTRL)) en_q <= wdata_i[0];
  end
  assign filt_en_o = en_q;

  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    if (PRESENT_MASK[g]) begin : g_on
      localparam logic [3:0] ENA_RST = (g == 0) ? 4'hF : 4'h0;
      logic [3:0]      ena_q;
      logic [ID_W-1:0] c0_q, c1_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ena_q <= ENA_RST;
          c0_q  <= '0;
          c1_q  <= '0;
        end else if (we_i) begin
          if (addr_i == ADDR_W'(ADDR_ENA))       ena_q <= wdata_i[4*g +: 4];
          if (addr_i == ADDR_W'(cfg_addr(g, 0))) c0_q  <= wdata_i;
          if (addr_i == ADDR_W'(cfg_addr(g, 1))) c1_q  <= wdata_i;
        end
      end
      assign type_ena_o[g] = ena_q;
      assign cfg0_o[g]     = c0_q;
      assign cfg1_o[g]     = c1_q;
    end else begin : g_off
      assign type_ena_o[g] = '0;
      assign cfg0_o[g]     = '0;
      assign cfg1_o[g]     = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))   rdata_o[0]    = en_q;
    if (addr_i == ADDR_W'(ADDR_ENA))    rdata_o[15:0] = type_ena_o;
    if (addr_i == ADDR_W'(ADDR_STATUS)) rdata_o[3:0]  = PRESENT_MASK;
    for (int unsigned i = 0; i < N_FILT; i++) begin
      if (addr_i == ADDR_W'(cfg_addr(i, 0))) rdata_o = cfg0_o[i];
      if (addr_i == ADDR_W'(cfg_addr(i, 1))) rdata_o = cfg1_o[i];
    end
  end
endmodule

// File: rtl/can_filt_mask_match.sv
module can_filt_mask_match #(
  parameter int unsigned ID_W = 29
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] val_i,
  output logic            hit_o
);
  assign hit_o = ((id_i ^ val_i) & mask_i) == '0;
endmodule

// File: rtl/can_filt_range_match.sv
module can_filt_range_match #(
  parameter int unsigned ID_W = 29
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] low_i,
  input  logic [ID_W-1:0] high_i,
  output logic            hit_o
);
  assign hit_o = (id_i >= low_i) && (id_i <= high_i);
endmodule

// File: rtl/can_id_filter_bank.sv
module can_id_filter_bank
  import can_filt_pkg::*;
#(
  parameter int unsigned ID_W         = 29,
  parameter int unsigned EXT_W        = 18,
  parameter int unsigned ADDR_W       = 4,
  parameter logic [3:0]  PRESENT_MASK = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [ID_W-1:0]   reg_wdata_i,
  output logic [ID_W-1:0]   reg_rdata_o,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              frm_ext_i,
  input  logic              frm_fd_i,
  output logic              accept_o,
  output logic              accept_vld_o
);
  logic                        filt_en;
  logic [N_FILT-1:0][3:0]      type_ena;
  logic [N_FILT-1:0][ID_W-1:0] cfg0, cfg1;
  logic [ID_W-1:0]             eff_id;
  frame_type_e                 ftype;
  logic [N_FILT-1:0]           raw_hit, hit;
  logic                        accept_d, accept_q, vld_q;

  can_filt_regs #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .PRESENT_MASK(PRESENT_MASK)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .filt_en_o(filt_en),
    .type_ena_o(type_ena), .cfg0_o(cfg0), .cfg1_o(cfg1)
  );

  // base-format frames compare with a zero extension
  assign eff_id = frm_ext_i ? frm_id_i : {frm_id_i[ID_W-1:EXT_W], {EXT_W{1'b0}}};
  assign ftype  = frame_type_e'({frm_fd_i, frm_ext_i});

  for (genvar g = 0; g < N_FILT; g++) begin : g_match
    if (g < N_MASK_FILT) begin : g_mask
      can_filt_mask_match #(.ID_W(ID_W)) mm_i (
        .id_i(eff_id), .mask_i(cfg0[g]), .val_i(cfg1[g]), .hit_o(raw_hit[g])
      );
    end else begin : g_range
      can_filt_range_match #(.ID_W(ID_W)) rm_i (
        .id_i(eff_id), .low_i(cfg0[g]), .high_i(cfg1[g]), .hit_o(raw_hit[g])
      );
    end
    assign hit[g] = PRESENT_MASK[g] & raw_hit[g] & type_ena[g][ftype];
  end

  assign accept_d = !(filt_en && (|PRESENT_MASK)) || (|hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= frm_valid_i;
      if (frm_valid_i) accept_q <= accept_d;
    end
  end

  assign accept_o     = accept_q;
  assign accept_vld_o = vld_q;
endmodule

module can_id_filter_bank_chk
  import can_filt_pkg::*;
#(
  parameter int unsigned ID_W         = 29,
  parameter int unsigned ADDR_W       = 4,
  parameter logic [3:0]  PRESENT_MASK = 4'hF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_valid_i,
  input logic              accept_o,
  input logic              accept_vld_o,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [ID_W-1:0]   reg_rdata_o,
  input logic              filt_en,
  input logic [15:0]       type_ena
);
  logic absent_slot;
  always_comb begin
    absent_slot = 1'b0;
    for (int unsigned i = 0; i < N_FILT; i++)
      if (!PRESENT_MASK[i] && (reg_addr_i == ADDR_W'(cfg_addr(i, 0)) ||
                               reg_addr_i == ADDR_W'(cfg_addr(i, 1))))
        absent_slot = 1'b1;
  end

  p_vld_after_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> accept_vld_o);
  p_hold_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> (!accept_vld_o && $stable(accept_o)));
  p_bypass_accepts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && !filt_en) |=> accept_o);
  p_no_type_rejects_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && filt_en && type_ena == 16'h0 && PRESENT_MASK != 4'h0) |=> !accept_o);
  p_absent_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_slot |-> reg_rdata_o == '0);
  p_status_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(ADDR_STATUS)) |-> reg_rdata_o == ID_W'(PRESENT_MASK));
endmodule

bind can_id_filter_bank can_id_filter_bank_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .PRESENT_MASK(PRESENT_MASK)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .frm_valid_i(frm_valid_i), .accept_o(accept_o),
  .accept_vld_o(accept_vld_o), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .filt_en(filt_en), .type_ena(type_ena)
);

// File: tb/can_id_filter_bank_tb_top.sv
module can_id_filter_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 29;
  localparam int ADDR_W = 4;
  localparam logic [3:0] PRES_F = 4'hF;
  localparam logic [3:0] PRES_P = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ID_W-1:0] wdata = '0;
  logic fv = 1'b0, fext = 1'b0, ffd = 1'b0;
  logic [ID_W-1:0] fid = '0;
  logic [ID_W-1:0] rd_f, rd_p;
  logic acc_f, vld_f, acc_p, vld_p;

  int checks = 0, errors = 0;

  logic            m_en;
  logic [3:0]      m_nib [4];
  logic [ID_W-1:0] m_c0 [4];
  logic [ID_W-1:0] m_c1 [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_id_filter_bank #(.PRESENT_MASK(PRES_F)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_f), .frm_valid_i(fv), .frm_id_i(fid), .frm_ext_i(fext), .frm_fd_i(ffd),
    .accept_o(acc_f), .accept_vld_o(vld_f));

  can_id_filter_bank #(.PRESENT_MASK(PRES_P)) dut_p_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_p), .frm_valid_i(fv), .frm_id_i(fid), .frm_ext_i(fext), .frm_fd_i(ffd),
    .accept_o(acc_p), .accept_vld_o(vld_p));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_acc(logic [3:0] pres, logic [ID_W-1:0] id, logic ext, logic fd);
    logic [ID_W-1:0] eff;
    logic [1:0] t;
    eff = ext ? id : {id[28:18], 18'b0};
    t = {fd, ext};
    if (!m_en || pres == 4'h0) return 1'b1;
    for (int i = 0; i < 3; i++)
      if (pres[i] && m_nib[i][t] && (((eff ^ m_c1[i]) & m_c0[i]) == '0)) return 1'b1;
    if (pres[3] && m_nib[3][t] && eff >= m_c0[3] && eff <= m_c1[3]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [ID_W-1:0] exp_rd(logic [3:0] pres, int a);
    logic [ID_W-1:0] r;
    r = '0;
    if (a == 0) r[0] = m_en;
    else if (a == 1) begin
      for (int i = 0; i < 4; i++) r[4*i +: 4] = pres[i] ? m_nib[i] : 4'h0;
    end else if (a >= 2 && a <= 9) begin
      int f;
      f = (a - 2) / 2;
      if (pres[f]) r = ((a - 2) % 2 == 0) ? m_c0[f] : m_c1[f];
    end else if (a == 10) r[3:0] = pres;
    return r;
  endfunction

  task automatic wr(input int a, input logic [ID_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 0) m_en = d[0];
    else if (a == 1) for (int i = 0; i < 4; i++) m_nib[i] = d[4*i +: 4];
    else if (a >= 2 && a <= 9) begin
      if ((a - 2) % 2 == 0) m_c0[(a-2)/2] = d; else m_c1[(a-2)/2] = d;
    end
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    addr = a[ADDR_W-1:0];
    #1;
    chk(rd_f == exp_rd(PRES_F, a), req, 32'(rd_f), 32'(exp_rd(PRES_F, a)));
    chk(rd_p == exp_rd(PRES_P, a), req, 32'(rd_p), 32'(exp_rd(PRES_P, a)));
  endtask

  task automatic frame(input logic [ID_W-1:0] id, input logic ext, input logic fd, input string req);
    logic ef, ep;
    ef = exp_acc(PRES_F, id, ext, fd);
    ep = exp_acc(PRES_P, id, ext, fd);
    @(negedge clk);
    fv = 1'b1; fid = id; fext = ext; ffd = fd;
    @(negedge clk);
    fv = 1'b0;
    chk(vld_f && vld_p, "R10 vld", 32'({vld_f, vld_p}), 32'h3);
    chk(acc_f == ef, req, 32'(acc_f), 32'(ef));
    chk(acc_p == ep, {req, " (partial bank)"}, 32'(acc_p), 32'(ep));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        a0, a1;
    void'($urandom(32'd4242));
    m_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_nib[i] = (i == 0) ? 4'hF : 4'h0;
      m_c0[i] = '0; m_c1[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!acc_f && !vld_f && !acc_p && !vld_p, "R1 outputs", 32'({acc_f, vld_f, acc_p, vld_p}), 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 12; a++) rd(a, "R1/R11/R9 reset readback");

    // R7 bypass: filtering off, all types disabled
    wr(1, '0);
    for (int k = 0; k < 8; k++) begin
      r = $urandom;
      frame(r[28:0], r[29], r[30], "R7 bypass");
    end

    // R3 exact match on filter A, extended frame
    wr(0, 29'h1);
    wr(1, 29'h000F);
    wr(2, {ID_W{1'b1}});
    wr(3, 29'h0ABCDEF1);
    frame(29'h0ABCDEF1, 1'b1, 1'b0, "R3 exact hit");
    frame(29'h0ABCDEF0, 1'b1, 1'b0, "R3 one-bit miss");
    wr(2, 29'h1FFFFFF0);
    frame(29'h0ABCDEFE, 1'b1, 1'b0, "R3 masked-off bits ignored");

    // R2 base frame: extension bits cleared before compare
    wr(2, {ID_W{1'b1}});
    wr(3, {11'h5A5, 18'h0});
    frame({11'h5A5, 18'h3C3C3}, 1'b0, 1'b0, "R2 base zero-extended hit");
    frame({11'h5A5, 18'h3C3C3}, 1'b1, 1'b0, "R2 same bits as extended miss");

    // R4 type gating: A allows classic base only
    wr(1, 29'h0001);
    frame({11'h5A5, 18'h0}, 1'b0, 1'b0, "R4 classic base allowed");
    frame({11'h5A5, 18'h0}, 1'b0, 1'b1, "R4 FD base blocked");

    // R5 range inclusive ends; A off
    wr(1, 29'hF000);
    wr(8, 29'd100);
    wr(9, 29'd200);
    frame(29'd99, 1'b1, 1'b1, "R5 below low");
    frame(29'd100, 1'b1, 1'b1, "R5 at low");
    frame(29'd200, 1'b1, 1'b0, "R5 at high");
    frame(29'd201, 1'b1, 1'b0, "R5 above high");

    // R8 filter B passes everything on full bank, absent on partial bank
    wr(1, 29'h00F0);
    wr(4, 29'h0);
    wr(5, 29'h12345);
    frame(29'h777, 1'b1, 1'b0, "R8 absent filter B never hits");
    rd(4, "R8 absent mask reads zero");
    rd(5, "R8 absent value reads zero");
    rd(1, "R8 absent nibble reads zero");
    wr(10, 29'h0);
    rd(10, "R9 status write ignored");

    // R10 idle cycle: vld drops, accept holds
    @(negedge clk);
    a0 = acc_f; a1 = acc_p;
    @(negedge clk);
    chk(!vld_f && !vld_p, "R10 vld low when idle", 32'({vld_f, vld_p}), 32'h0);
    chk(acc_f == a0 && acc_p == a1, "R10 accept held", 32'({acc_f, acc_p}), 32'({a0, a1}));

    // R6 random configurations vs model
    for (int round = 0; round < 40; round++) begin
      r = $urandom; wr(0, {28'h0, (r[2:0] != 3'h0)});
      r = $urandom; wr(1, {13'h0, r[15:0]});
      for (int f = 0; f < 3; f++) begin
        logic [31:0] q;
        r = $urandom; q = $urandom;
        wr(2 + 2*f, r[28:0] & q[28:0]);
        r = $urandom; wr(3 + 2*f, r[28:0]);
      end
      r = $urandom; wr(8, r[28:0]);
      begin
        logic [31:0] q;
        q = $urandom;
        wr(9, m_c0[3] + {13'h0, q[15:0]});
      end
      for (int a = 0; a < 12; a++) if (a % 3 == round % 3) rd(a, "R11 random readback");
      for (int k = 0; k < 20; k++) begin
        logic [31:0] q;
        logic [ID_W-1:0] id;
        r = $urandom; q = $urandom;
        case (r[1:0])
          2'd0: id = q[28:0];
          2'd1: id = m_c1[r[3:2] % 3] ^ (q[28:0] & ~m_c0[r[3:2] % 3]);
          2'd2: id = m_c0[3] + {26'h0, q[2:0]};
          default: id = m_c1[3] - {26'h0, q[2:0]} + 29'd1;
        endcase
        frame(id, r[4], r[5], "R6 random decision");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule